// File: doc/BRIEF.md
# Transceiver Power-Mode Controller

This block decides which analog sections of a multi-band radio transceiver are powered. Three mode requests (synthesizer-only, receive, transmit) arrive twice: as dedicated hardware pins and as bits from the serial programming register. The two copies of each request are ORed, and the result is decoded into enables for the synthesizers, the receive chain and the transmit chain. The synthesizer-only mode lets the frequency synthesizers settle before the radio enters receive or transmit.

Three further enables are derived from the mode. The IF synthesizer and VCO can be brought up by a dedicated register bit, independently of transmit, and otherwise follow transmit. The low-noise amplifier can be switched off inside receive for DC-offset calibration while the rest of the receiver stays powered. The band, image-sideband and transmit charge-pump current selections pass through as static controls. Every output comes from a flop, so inputs that change together cannot cause a glitch on a power-domain enable. A request for receive and transmit together is illegal: it is flagged and changes nothing.

Top module: `pm_power_ctrl`

## Requirements
- R1: While rst_ni is low, every enable, band_o, sideband_o, cp_half_o and illegal_o are 0 and mode_o is 2'b00, whatever the inputs do.
- R2: A synthesizer-only request (index 0 of the request vectors) with no receive or transmit request sets syn_en_o to 1 and rx_en_o and tx_en_o to 0 on the next clock edge.
- R3: A receive request (index 1) without a transmit request sets syn_en_o and rx_en_o to 1 and tx_en_o to 0 on the next clock edge. This holds whether or not the synthesizer request is also present.
- R4: A transmit request (index 2) without a receive request sets syn_en_o and tx_en_o to 1 and rx_en_o to 0 on the next clock edge.
- R5: mode_o reports the registered mode as 2'b00 idle, 2'b01 synthesizer only, 2'b10 receive, 2'b11 transmit. With no request at all, the mode is idle and syn_en_o, rx_en_o and tx_en_o are 0.
- R6: Each request is the OR of its pin in mode_pin_i and its bit in mode_bit_i, so either source alone selects the mode.
- R7: When receive and transmit are both requested, syn_en_o, rx_en_o, tx_en_o and mode_o keep their previous values and illegal_o is 1 on the next edge. illegal_o is 0 after any edge at which the requests were legal.
- R8: ifsyn_en_o is 1 when ifsyn_bit_i is 1 or the registered transmit enable is 1, and 0 otherwise.
- R9: lna_en_o is 1 only when the receiver is enabled and lna_bit_i is 1. lna_bit_i = 0 leaves rx_en_o unchanged.
- R10: band_o, sideband_o and cp_half_o copy band_bit_i (0 GSM with halved LO, 1 DCS/PCS), sideband_bit_i (0 supradyne, 1 infradyne) and cp_half_bit_i (0 nominal, 1 halved current) one clock later, independently of the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_pin_i | input | 3 | Hardware mode requests: [0] synth, [1] receive, [2] transmit |
| mode_bit_i | input | 3 | Register mode requests, same bit order |
| ifsyn_bit_i | input | 1 | Independent IF synthesizer/VCO enable bit |
| lna_bit_i | input | 1 | LNA on (1) / off (0) bit |
| band_bit_i | input | 1 | Band select bit |
| sideband_bit_i | input | 1 | Image sideband select bit |
| cp_half_bit_i | input | 1 | TX charge-pump current halving bit |
| syn_en_o | output | 1 | Synthesizer power enable |
| rx_en_o | output | 1 | Receiver power enable |
| tx_en_o | output | 1 | Transmitter power enable |
| lna_en_o | output | 1 | LNA power enable |
| ifsyn_en_o | output | 1 | IF synthesizer and VCO enable |
| band_o | output | 1 | Registered band select |
| sideband_o | output | 1 | Registered sideband select |
| cp_half_o | output | 1 | Registered charge-pump current select |
| mode_o | output | 2 | Registered mode code |
| illegal_o | output | 1 | Receive and transmit were both requested |

## Verification
The bench targets the receive-plus-transmit conflict, including the case where one half comes from a pin and the other from a register bit. A design that decodes the conflict would power both chains or fall to idle instead of holding the previous state. It steps from a held state straight back to a legal request and checks that the flag drops after a single cycle and is not sticky. It checks the IF enable with the transmit chain off, to catch a design that gates the dedicated bit with transmit, and the LNA bit with receive on, to catch a design that also drops the receiver. The static selections are driven during illegal requests, where a design that froze them with the mode would fall behind.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned REQ_W   = 3;
  localparam int unsigned SYN_IDX = 0;
  localparam int unsigned RX_IDX  = 1;
  localparam int unsigned TX_IDX  = 2;
  localparam int unsigned SEL_W   = 3;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_SYN  = 2'b01,
    MODE_RX   = 2'b10,
    MODE_TX   = 2'b11
  } pm_mode_e;

  typedef struct packed {
    logic     syn;
    logic     rx;
    logic     tx;
    pm_mode_e mode;
  } pm_core_t;
endpackage

// File: rtl/pm_req_merge.sv
module pm_req_merge #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] bit_i,
  output logic [W-1:0] req_o
);
  for (genvar g = 0; g < W; g++) begin : g_or
    assign req_o[g] = pin_i[g] | bit_i[g];
  end
endmodule

// File: rtl/pm_mode_decode.sv
module pm_mode_decode
  import pm_pkg::*;
(
  input  pm_core_t         cur_i,
  input  logic [REQ_W-1:0] req_i,
  output pm_core_t         nxt_o,
  output logic             clash_o
);
  always_comb begin
    clash_o = req_i[RX_IDX] & req_i[TX_IDX];
    nxt_o   = cur_i;
    if (!clash_o) begin
      nxt_o.rx  = req_i[RX_IDX];
      nxt_o.tx  = req_i[TX_IDX];
      // receive and transmit need the LO running
      nxt_o.syn = |req_i;
      if (req_i[TX_IDX])       nxt_o.mode = MODE_TX;
      else if (req_i[RX_IDX])  nxt_o.mode = MODE_RX;
      else if (req_i[SYN_IDX]) nxt_o.mode = MODE_SYN;
      else                     nxt_o.mode = MODE_IDLE;
    end
  end
endmodule

// File: rtl/pm_enable_regs.sv
module pm_enable_regs
  import pm_pkg::*;
#(
  parameter int unsigned N_SEL = SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pm_core_t         nxt_i,
  input  logic             clash_i,
  input  logic             ifsyn_bit_i,
  input  logic             lna_bit_i,
  input  logic [N_SEL-1:0] sel_i,
  output pm_core_t         core_q_o,
  output logic             ifsyn_q_o,
  output logic             lna_q_o,
  output logic             err_q_o,
  output logic [N_SEL-1:0] sel_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_q_o  <= '{syn: 1'b0, rx: 1'b0, tx: 1'b0, mode: MODE_IDLE};
      ifsyn_q_o <= 1'b0;
      lna_q_o   <= 1'b0;
      err_q_o   <= 1'b0;
    end else begin
      core_q_o  <= nxt_i;
      ifsyn_q_o <= nxt_i.tx | ifsyn_bit_i;
      lna_q_o   <= nxt_i.rx & lna_bit_i;
      err_q_o   <= clash_i;
    end
  end

  for (genvar g = 0; g < N_SEL; g++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_q_o[g] <= 1'b0;
      else         sel_q_o[g] <= sel_i[g];
    end
  end

  p_rx_tx_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(core_q_o.rx && core_q_o.tx));
  p_hold_on_clash_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash_i |=> ($stable(core_q_o) && err_q_o));
  p_syn_under_chain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_q_o.rx || core_q_o.tx) |-> core_q_o.syn);
  p_lna_needs_rx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lna_q_o |-> core_q_o.rx);
  p_ifsyn_with_tx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_q_o.tx |-> ifsyn_q_o);
  p_mode_tx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_q_o.mode == MODE_TX) |-> core_q_o.tx);
endmodule

// File: rtl/pm_power_ctrl.sv
module pm_power_ctrl
  import pm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_pin_i,
  input  logic [2:0] mode_bit_i,
  input  logic       ifsyn_bit_i,
  input  logic       lna_bit_i,
  input  logic       band_bit_i,
  input  logic       sideband_bit_i,
  input  logic       cp_half_bit_i,
  output logic       syn_en_o,
  output logic       rx_en_o,
  output logic       tx_en_o,
  output logic       lna_en_o,
  output logic       ifsyn_en_o,
  output logic       band_o,
  output logic       sideband_o,
  output logic       cp_half_o,
  output logic [1:0] mode_o,
  output logic       illegal_o
);
  logic [REQ_W-1:0] req;
  pm_core_t         core_q, core_d;
  logic             clash;
  logic [SEL_W-1:0] sel_q;

  pm_req_merge #(.W(REQ_W)) i_merge (
    .pin_i (mode_pin_i),
    .bit_i (mode_bit_i),
    .req_o (req)
  );

  pm_mode_decode i_decode (
    .cur_i   (core_q),
    .req_i   (req),
    .nxt_o   (core_d),
    .clash_o (clash)
  );

  pm_enable_regs #(.N_SEL(SEL_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nxt_i       (core_d),
    .clash_i     (clash),
    .ifsyn_bit_i (ifsyn_bit_i),
    .lna_bit_i   (lna_bit_i),
    .sel_i       ({cp_half_bit_i, sideband_bit_i, band_bit_i}),
    .core_q_o    (core_q),
    .ifsyn_q_o   (ifsyn_en_o),
    .lna_q_o     (lna_en_o),
    .err_q_o     (illegal_o),
    .sel_q_o     (sel_q)
  );

  assign syn_en_o   = core_q.syn;
  assign rx_en_o    = core_q.rx;
  assign tx_en_o    = core_q.tx;
  assign mode_o     = core_q.mode;
  assign band_o     = sel_q[0];
  assign sideband_o = sel_q[1];
  assign cp_half_o  = sel_q[2];
endmodule

// File: tb/test_pm_power_ctrl.sv
module test_pm_power_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] pin = '0, bits = '0;
  logic ifb = 0, lnab = 0, bandb = 0, sbb = 0, cpb = 0;
  logic syn_en, rx_en, tx_en, lna_en, ifsyn_en, band, sb, cph, illegal;
  logic [1:0] mode;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit m_syn, m_rx, m_tx, m_err, m_if, m_lna;
  bit [1:0] m_mode;
  bit [2:0] m_sel;

  always #5 clk = ~clk;

  pm_power_ctrl i_pm_power_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_pin_i(pin), .mode_bit_i(bits),
    .ifsyn_bit_i(ifb), .lna_bit_i(lnab), .band_bit_i(bandb),
    .sideband_bit_i(sbb), .cp_half_bit_i(cpb),
    .syn_en_o(syn_en), .rx_en_o(rx_en), .tx_en_o(tx_en), .lna_en_o(lna_en),
    .ifsyn_en_o(ifsyn_en), .band_o(band), .sideband_o(sb), .cp_half_o(cph),
    .mode_o(mode), .illegal_o(illegal)
  );

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    chk("R2 syn_en", {1'b0, syn_en}, {1'b0, m_syn});
    chk("R3 rx_en", {1'b0, rx_en}, {1'b0, m_rx});
    chk("R4 tx_en", {1'b0, tx_en}, {1'b0, m_tx});
    chk("R5 mode", mode, m_mode);
    chk("R7 illegal", {1'b0, illegal}, {1'b0, m_err});
    chk("R8 ifsyn_en", {1'b0, ifsyn_en}, {1'b0, m_if});
    chk("R9 lna_en", {1'b0, lna_en}, {1'b0, m_lna});
    chk("R10 band", {1'b0, band}, {1'b0, m_sel[0]});
    chk("R10 sideband", {1'b0, sb}, {1'b0, m_sel[1]});
    chk("R10 cp_half", {1'b0, cph}, {1'b0, m_sel[2]});
  endtask

  // reference: one clock after the inputs, R6 merges pin and bit
  task automatic model_tick();
    bit s, r, t;
    s = pin[0] | bits[0];
    r = pin[1] | bits[1];
    t = pin[2] | bits[2];
    if (r && t) m_err = 1;
    else begin
      m_err = 0;
      m_rx = r; m_tx = t; m_syn = s | r | t;
      m_mode = t ? 2'd3 : r ? 2'd2 : s ? 2'd1 : 2'd0;
    end
    m_if  = m_tx | ifb;
    m_lna = m_rx & lnab;
    m_sel = {cpb, sbb, bandb};
  endtask

  task automatic step(logic [2:0] p, logic [2:0] b, logic fi, logic ln,
                      logic [2:0] sel);
    pin = p; bits = b; ifb = fi; lnab = ln; {cpb, sbb, bandb} = sel;
    @(posedge clk);
    model_tick();
    @(negedge clk);
    compare_all();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds everything off even with requests active
    @(negedge clk);
    pin = 3'b111; bits = 3'b111; ifb = 1; lnab = 1; {cpb, sbb, bandb} = 3'b111;
    @(negedge clk); @(negedge clk);
    chk("R1 syn_en", {1'b0, syn_en}, 2'd0);
    chk("R1 rx_en", {1'b0, rx_en}, 2'd0);
    chk("R1 tx_en", {1'b0, tx_en}, 2'd0);
    chk("R1 lna_en", {1'b0, lna_en}, 2'd0);
    chk("R1 ifsyn_en", {1'b0, ifsyn_en}, 2'd0);
    chk("R1 mode", mode, 2'd0);
    chk("R1 illegal", {1'b0, illegal}, 2'd0);
    chk("R1 statics", {1'b0, band | sb | cph}, 2'd0);
    pin = '0; bits = '0; ifb = 0; lnab = 0; {cpb, sbb, bandb} = '0;
    rst_n = 1'b1;
    step(3'b001, 3'b000, 0, 0, 3'b000); // R2 synth only by pin
    step(3'b011, 3'b000, 0, 1, 3'b001); // R3 receive with synth
    step(3'b000, 3'b010, 0, 1, 3'b000); // R6 receive by bit only
    step(3'b000, 3'b010, 0, 0, 3'b000); // R9 LNA off, receiver stays
    step(3'b000, 3'b101, 0, 0, 3'b100); // R4 transmit by bits
    step(3'b110, 3'b000, 0, 1, 3'b010); // R7 clash by pins, hold tx
    step(3'b010, 3'b100, 1, 1, 3'b111); // R7 clash pin+bit, statics move (R10)
    step(3'b000, 3'b000, 0, 0, 3'b000); // R5 idle, flag drops
    step(3'b000, 3'b000, 1, 0, 3'b000); // R8 IF synth alone
    step(3'b010, 3'b000, 0, 1, 3'b000); // R3 rx from idle
    step(3'b000, 3'b110, 0, 1, 3'b000); // R7 clash holds rx, lna follows bit
    step(3'b000, 3'b110, 0, 0, 3'b000); // R9 hold rx, lna off
    step(3'b100, 3'b000, 0, 0, 3'b000); // R4 tx direct after clash
    for (int i = 0; i < 600; i++)
      step(3'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule